// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the byte-wide, memory-mapped control plane of an asynchronous serial port. A host reaches two mode registers through a one-bit pointer, reads a status byte and an interrupt status byte, writes an interrupt mask, and issues commands. One command write carries three fields, for miscellaneous actions, for the transmitter and for the receiver, and all three act in that same write. The block drives a single level-sensitive interrupt line.

On the transmit side a single holding byte is offered to a byte-level valid/ready sink. On the receive side an external queue reports non-empty and full. The block pops that queue when the host reads the data offset, and flushes it on a receiver reset command. The receive interrupt follows either data-ready or queue-full, as chosen by a bit of the first mode register. Bit timing, baud generation and framing lie outside this block. The two divider bytes are read-only constants.

Top module: `uart_ctl_regs`

## Requirements
- R1: Decode uses the 6-bit address. 0x18 reads the DIV_A parameter (default 0x5A), 0x1C reads DIV_B (default 0xC3), and every unlisted offset (for example 0x10 or 0x3C) reads 0x00. A write to status offset 0x04 changes nothing.
- R2: Offset 0x00 reads and writes mode register [ptr]. After any write to 0x00 the pointer is 1. Reset and the pointer-clear command set it to 0.
- R3: Status (read at 0x04) is bit0 queue not empty, bit1 queue full, bit2 transmitter enabled, bit3 transmit holding empty, and bits 7:4 are zero.
- R4: Interrupt status (read at 0x14) is bit0 = status bit2, bit1 = receive interrupt, bit2 = break-change flag and bit7 = 0. A `brk_evt` pulse sets the break-change flag, and it stays set until cleared by command.
- R5: The receive interrupt equals queue full when bit6 of mode register 0 is 1, and queue not empty otherwise.
- R6: `irq` is 1 exactly when (interrupt status AND mask) is non-zero. The mask is written at 0x14.
- R7: A command write at 0x08 decodes bits [6:4] as follows. 1 clears the mode pointer. 2 disables the receiver and pulses `rxq_flush`. 3 disables the transmitter and marks the holding byte empty. 5 clears the break-change flag. Values 0, 4, 6 and 7 do nothing.
- R8: Bits [3:2] (transmitter) and [1:0] (receiver) decode as 1 = enable, 2 = disable, 0 and 3 = no change. Field actions apply after the bits [6:4] action of the same write.
- R9: A write at 0x0C loads the holding byte and clears empty. `tx_valid` = enabled AND not empty. `tx_data` holds steady while `tx_ready` is low, and empty is set only in the cycle after a valid/ready handshake.
- R10: After reset both mode registers, the mask, the break-change flag and both enables are 0, status reads 0x08 and `irq` is 0.
- R11: A command write with field [3:2] or [1:0] equal to 3 raises `cmd_err` for exactly the following cycle.
- R12: A read at 0x0C returns the queue head and pops it when the queue is not empty. It returns 0x00 with no pop when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rxq_ne | input | 1 | Receive queue not empty |
| rxq_full | input | 1 | Receive queue full |
| rxq_data | input | 8 | Receive queue head byte |
| rxq_pop | output | 1 | Pop receive queue head |
| rxq_flush | output | 1 | Empty the receive queue |
| rx_en | output | 1 | Receiver enabled (queue may accept bytes) |
| brk_evt | input | 1 | Break detected pulse |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Sink accepts byte |
| irq | output | 1 | Level interrupt |
| cmd_err | output | 1 | Reserved command field seen last cycle |

## Verification
Read data, `rxq_pop` and `irq` are combinational from registered state and the queue flags. They are valid in the same cycle as the read strobe, or as soon as the flags change. Every register write, command, handshake and break pulse shows at the ports one clock edge later. Queue effects of a pop or flush appear one edge after that edge, through the bench's queue model. The bench drives strobes on falling edges and samples half a cycle after the rising edge that completes each access, so every result is read in the cycle it is due.

// File: rtl/uart_ctl_pkg.sv
// Shared offsets, command field codes and decoded command record for the
// UART control register file. Assumes a 6-bit byte offset decode.
package uart_ctl_pkg;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_INT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_DIVA = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DIVB = 6'h1C;

    typedef enum logic [2:0] {
        MISC_NOP, MISC_PTR_CLR, MISC_RX_RST, MISC_TX_RST,
        MISC_ERR_CLR, MISC_BRK_CLR, MISC_BRK_ON, MISC_BRK_OFF
    } misc_e;

    typedef enum logic [1:0] {DIR_KEEP, DIR_ON, DIR_OFF, DIR_RSVD} dir_e;

    typedef struct packed {
        logic ptr_clr;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
        logic bad;
    } cmd_t;
endpackage

// File: rtl/uart_cmd_dec.sv
// Splits a command byte into its three fields and flags each action.
// Assumes the caller qualifies the result with the command write strobe.
module uart_cmd_dec
    import uart_ctl_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output cmd_t              dec
);
    misc_e misc;
    dir_e  txf;
    dir_e  rxf;

    assign misc = misc_e'(cmd[6:4]);
    assign txf  = dir_e'(cmd[3:2]);
    assign rxf  = dir_e'(cmd[1:0]);

    // Flag each action named by the three fields.
    always_comb begin
        dec         = '0;
        dec.ptr_clr = (misc == MISC_PTR_CLR);
        dec.rx_rst  = (misc == MISC_RX_RST);
        dec.tx_rst  = (misc == MISC_TX_RST);
        dec.brk_clr = (misc == MISC_BRK_CLR);
        dec.tx_on   = (txf == DIR_ON);
        dec.tx_off  = (txf == DIR_OFF);
        dec.rx_on   = (rxf == DIR_ON);
        dec.rx_off  = (rxf == DIR_OFF);
        dec.bad     = (txf == DIR_RSVD) || (rxf == DIR_RSVD);
    end
endmodule

// File: rtl/uart_tx_hold.sv
// Transmit enable and single holding byte offered on a valid/ready output.
// Assumes load and the transmitter reset command never fall in one cycle.
module uart_tx_hold
    import uart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] ldata,
    input  logic              rst_cmd,
    input  logic              on_cmd,
    input  logic              off_cmd,
    input  logic              tx_ready,
    output logic              tx_en,
    output logic              tx_empty,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic en_nx;
    logic empty_nx;

    assign tx_valid = tx_en && !tx_empty;

    // Next enable: misc reset first, then the transmitter field.
    always_comb begin
        en_nx = tx_en;
        if (rst_cmd) en_nx = 1'b0;
        if (on_cmd)  en_nx = 1'b1;
        if (off_cmd) en_nx = 1'b0;
    end

    // Next empty flag: handshake or reset empties, a load fills.
    always_comb begin
        empty_nx = tx_empty;
        if (tx_valid && tx_ready) empty_nx = 1'b1;
        if (rst_cmd)              empty_nx = 1'b1;
        if (load)                 empty_nx = 1'b0;
    end

    // Holding state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            tx_empty <= 1'b1;
            tx_data  <= '0;
        end else begin
            tx_en    <= en_nx;
            tx_empty <= empty_nx;
            if (load) tx_data <= ldata;
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !load && !rst_cmd && !off_cmd)
        |=> (tx_valid && $stable(tx_data)));
    // R9
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !load) |=> !tx_valid);
endmodule

// File: rtl/uart_irq_gen.sv
// Builds interrupt status from live status bits and the break-change flag,
// and masks it onto the level interrupt. Assumes inputs are synchronous.
module uart_irq_gen
    import uart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_rdy,
    input  logic              rx_ne,
    input  logic              rx_full,
    input  logic              src_full,
    input  logic              brk_evt,
    input  logic              brk_clr,
    input  logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] isr,
    output logic              irq
);
    logic brk_flag;
    logic rx_int;

    assign rx_int = src_full ? rx_full : rx_ne;
    assign isr    = {1'b0, 4'b0, brk_flag, rx_int, tx_rdy};
    assign irq    = |(isr & mask);

    // Break-change flag: a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       brk_flag <= 1'b0;
        else if (brk_evt) brk_flag <= 1'b1;
        else if (brk_clr) brk_flag <= 1'b0;
    end

    // R4
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> isr[2]);
    // R7
    brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !brk_evt) |=> !isr[2]);
endmodule

// File: rtl/uart_ctl_regs.sv
// Byte-wide register file of a serial port: mode pair behind a pointer,
// status, interrupt status/mask, command, transmit holding byte and a read
// port onto an external receive queue. Assumes one access per cycle.
module uart_ctl_regs
    import uart_ctl_pkg::*;
#(
    parameter logic [7:0] DIV_A = 8'h5A,
    parameter logic [7:0] DIV_B = 8'hC3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        rxq_ne,
    input  logic        rxq_full,
    input  logic [7:0]  rxq_data,
    output logic        rxq_pop,
    output logic        rxq_flush,
    output logic        rx_en,
    input  logic        brk_evt,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        irq,
    output logic        cmd_err
);
    localparam int unsigned MODE_N = 2;
    localparam int unsigned SRC_BIT = 6;

    logic [BYTE_W-1:0] mode_q [MODE_N];
    logic              ptr;
    logic [BYTE_W-1:0] mask_q;
    logic              wr_mode, wr_cmd, wr_data, wr_mask;
    cmd_t              dec;
    cmd_t              act;
    logic              tx_en, tx_empty;
    logic [BYTE_W-1:0] status, isr;

    assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_mask = bus_wr && (bus_addr == OFS_INT);

    uart_cmd_dec u_dec (.cmd(bus_wdata), .dec(dec));
    assign act = wr_cmd ? dec : '0;

    uart_tx_hold u_tx (
        .clk(clk), .rst_n(rst_n), .load(wr_data), .ldata(bus_wdata),
        .rst_cmd(act.tx_rst), .on_cmd(act.tx_on), .off_cmd(act.tx_off),
        .tx_ready(tx_ready), .tx_en(tx_en), .tx_empty(tx_empty),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    assign status = {4'b0, tx_empty, tx_en, rxq_full, rxq_ne};

    uart_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .tx_rdy(tx_en), .rx_ne(rxq_ne),
        .rx_full(rxq_full), .src_full(mode_q[0][SRC_BIT]),
        .brk_evt(brk_evt), .brk_clr(act.brk_clr), .mask(mask_q),
        .isr(isr), .irq(irq)
    );

    // Mode registers, one per pointer value.
    for (genvar g = 0; g < MODE_N; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)                          mode_q[g] <= '0;
            else if (wr_mode && (ptr == 1'(g)))  mode_q[g] <= bus_wdata;
        end
    end

    // Mode pointer: a mode write advances it, the command clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr <= 1'b0;
        else if (wr_mode)     ptr <= 1'b1;
        else if (act.ptr_clr) ptr <= 1'b0;
    end

    // Receiver enable: misc reset first, then the receiver field.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_en <= 1'b0;
        else if (act.rx_on)                rx_en <= 1'b1;
        else if (act.rx_off || act.rx_rst) rx_en <= 1'b0;
    end

    // Interrupt mask and reserved-field pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cmd_err <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= bus_wdata;
            cmd_err <= act.bad;
        end
    end

    assign rxq_flush = act.rx_rst;
    assign rxq_pop   = bus_rd && (bus_addr == OFS_DATA) && rxq_ne;

    // Read data selection by offset.
    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q[ptr];
            OFS_STAT: bus_rdata = status;
            OFS_DATA: bus_rdata = rxq_ne ? rxq_data : '0;
            OFS_INT:  bus_rdata = isr;
            OFS_DIVA: bus_rdata = DIV_A;
            OFS_DIVB: bus_rdata = DIV_B;
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    mode_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (ptr == 1'b1));
    // R12
    pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> (bus_rd && rxq_ne));
    // R11
    cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && ((bus_wdata[3:2] == 2'b11) || (bus_wdata[1:0] == 2'b11)))
        |=> cmd_err);
    // R11
    cmd_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !wr_cmd) |=> !cmd_err);
endmodule

// File: tb/sim_uart_ctl_regs.sv
module sim_uart_ctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxq_ne, rxq_full, rxq_pop, rxq_flush, rx_en;
    logic [7:0] rxq_data;
    logic       brk_evt = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid, tx_ready = 1'b0, irq, cmd_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_ctl_regs u0 (.*);

    // Behavioural 4-deep receive queue.
    logic [7:0] q [4];
    int         cnt;
    logic       push_req = 1'b0;
    logic [7:0] push_byte = '0;
    assign rxq_ne   = (cnt != 0);
    assign rxq_full = (cnt == 4);
    assign rxq_data = q[0];
    always @(posedge clk) begin
        if (!rst_n || rxq_flush) cnt <= 0;
        else if (rxq_pop) begin
            for (int i = 0; i < 3; i++) q[i] <= q[i+1];
            cnt <= cnt - 1;
        end else if (push_req && rx_en && cnt < 4) begin
            q[cnt] <= push_byte;
            cnt <= cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        push_req = 1'b1; push_byte = b;
        @(negedge clk);
        push_req = 1'b0;
    endtask

    // {write, tag, addr, data-or-expected}
    localparam int NV = 17;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 4'd2,  6'h00, 8'h40},   // R2 mode 0
        {1'b1, 4'd2,  6'h00, 8'h13},   // R2 mode 1
        {1'b0, 4'd2,  6'h00, 8'h13},   // R2 pointer stays 1
        {1'b1, 4'd7,  6'h08, 8'h10},   // R7 pointer clear
        {1'b0, 4'd2,  6'h00, 8'h40},
        {1'b0, 4'd3,  6'h04, 8'h08},   // R3 idle status
        {1'b0, 4'd1,  6'h18, 8'h5A},   // R1 divider bytes
        {1'b0, 4'd1,  6'h1C, 8'hC3},
        {1'b0, 4'd1,  6'h10, 8'h00},   // R1 unlisted
        {1'b0, 4'd1,  6'h3C, 8'h00},
        {1'b1, 4'd1,  6'h04, 8'hFF},   // R1 status write ignored
        {1'b0, 4'd1,  6'h04, 8'h08},
        {1'b1, 4'd8,  6'h08, 8'h04},   // R8 transmitter on
        {1'b0, 4'd3,  6'h04, 8'h0C},
        {1'b0, 4'd4,  6'h14, 8'h01},   // R4 transmit bit
        {1'b1, 4'd6,  6'h14, 8'h01},   // R6 mask
        {1'b0, 4'd4,  6'h14, 8'h01}
    };

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd(6'h04, v); chk("R10 status", v, 8'h08);
        rd(6'h14, v); chk("R10 isr", v, 8'h00);
        rd(6'h00, v); chk("R10 mode", v, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        chk("R10 rx_en", {7'b0, rx_en}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) wr(VEC[i][13:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][13:8], v);
                chk($sformatf("R%0d vec %0d", VEC[i][17:14], i), v, VEC[i][7:0]);
            end
        end
        chk("R6 irq masked tx", {7'b0, irq}, 8'h01);

        // R9 transmit hold and handshake
        wr(6'h0C, 8'hA5);
        chk("R9 valid", {7'b0, tx_valid}, 8'h01);
        chk("R9 data", tx_data, 8'hA5);
        rd(6'h04, v); chk("R9 status busy", v, 8'h04);
        repeat (3) @(negedge clk);
        chk("R9 held", tx_data, 8'hA5);
        chk("R9 still valid", {7'b0, tx_valid}, 8'h01);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R9 sent", {7'b0, tx_valid}, 8'h00);
        rd(6'h04, v); chk("R9 empty again", v, 8'h0C);
        wr(6'h08, 8'h08);                       // R8 transmitter off
        wr(6'h0C, 8'h3C);
        rd(6'h04, v); chk("R9 held while off", v, 8'h00);
        chk("R9 no valid when off", {7'b0, tx_valid}, 8'h00);
        wr(6'h08, 8'h30);                       // R7 transmitter reset
        rd(6'h04, v); chk("R7 tx reset", v, 8'h08);

        // R5 receive interrupt on full (mode 0 bit6 = 1)
        wr(6'h08, 8'h01);
        chk("R8 rx on", {7'b0, rx_en}, 8'h01);
        wr(6'h14, 8'h02);
        push(8'h11); push(8'h22);
        rd(6'h04, v); chk("R3 ready", v, 8'h09);
        chk("R5 not full no irq", {7'b0, irq}, 8'h00);
        push(8'h33); push(8'h44);
        rd(6'h04, v); chk("R3 full", v, 8'h0B);
        chk("R5 full irq", {7'b0, irq}, 8'h01);
        rd(6'h0C, v); chk("R12 head", v, 8'h11);
        @(negedge clk);
        chk("R5 after pop", {7'b0, irq}, 8'h00);
        rd(6'h0C, v); chk("R12 next", v, 8'h22);
        wr(6'h08, 8'h20);                       // R7 receiver reset
        chk("R7 rx off", {7'b0, rx_en}, 8'h00);
        @(negedge clk);
        rd(6'h04, v); chk("R7 flushed", v, 8'h08);
        rd(6'h0C, v); chk("R12 empty reads 0", v, 8'h00);

        // R5 receive interrupt on ready (mode 0 bit6 = 0)
        wr(6'h08, 8'h11);
        wr(6'h00, 8'h00);
        push(8'h77);
        rd(6'h14, v); chk("R5 ready source", v, 8'h02);
        chk("R6 rx irq", {7'b0, irq}, 8'h01);
        rd(6'h0C, v); chk("R12 pop", v, 8'h77);

        // R4 break-change flag and R7 clear
        @(negedge clk); brk_evt = 1'b1;
        @(negedge clk); brk_evt = 1'b0;
        rd(6'h14, v); chk("R4 break", v, 8'h04);
        wr(6'h08, 8'h40);                       // misc 4: no effect
        rd(6'h14, v); chk("R7 misc 4 none", v, 8'h04);
        wr(6'h08, 8'h50);
        rd(6'h14, v); chk("R7 break clear", v, 8'h00);

        // R8 all fields in one write
        wr(6'h08, 8'h26);
        chk("R8 rx off", {7'b0, rx_en}, 8'h00);
        rd(6'h04, v); chk("R8 tx on", v, 8'h0C);
        wr(6'h08, 8'h35);
        chk("R8 rx on after reset", {7'b0, rx_en}, 8'h01);
        rd(6'h04, v); chk("R8 tx on after reset", v, 8'h0C);

        // R11 reserved fields
        wr(6'h08, 8'h0F);
        chk("R11 err pulse", {7'b0, cmd_err}, 8'h01);
        chk("R11 rx kept", {7'b0, rx_en}, 8'h01);
        @(negedge clk);
        chk("R11 err gone", {7'b0, cmd_err}, 8'h00);
        rd(6'h04, v); chk("R11 tx kept", v, 8'h0C);

        wr(6'h14, 8'h00);
        chk("R6 mask off", {7'b0, irq}, 8'h00);

        // R10 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(6'h04, v); chk("R10 status again", v, 8'h08);
        rd(6'h00, v); chk("R10 mode again", v, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule